// File: doc/BRIEF.md
# Multicart Outer Bank Register and PRG Address Mapper

This block sits next to an existing 8 KB/1 KB banking core on a cartridge. It adds one outer control register that software loads by writing anywhere in CPU space 0x6000-0x7FFF. The value comes from the CPU address lines that carry the write. The data bus is not used. From that register, the CPU address and the bank numbers the core already produces, the block forms the PRG ROM address. It also picks one of two PRG ROMs: a 512 KB main ROM or a 32 KB boot ROM. It supplies the upper CHR address lines as well.

After reset the boot ROM fills all of 0x8000-0xFFFF. Once software sets the main-ROM select bit, the mapper works in one of three modes:
- **Core mode:** the core's 8 KB banks are used, confined to a 128 KB outer bank.
- **Fixed-16 mode:** one 16 KB page appears twice.
- **Fixed-32 mode:** one 32 KB page is mapped.

Two mechanisms guard the register. A self-lock bit freezes it completely. The main-ROM select bit is sticky. The block also watches the core's RAM-protect register so that writes are refused whenever that register would refuse RAM writes.

Top module: `mb_multicart_mapper`

## Requirements
- R1: Synchronous reset clears the outer register and the snooped protect state. After reset, every CPU read in 0x8000-0xFFFF selects the boot ROM.
- R2: A CPU write with A15..A13 = 011 loads the register from address bits: A8 main-select, A6 lock, A5 core-mode, A4..A3 outer bank, A2..A0 inner page. The data bus and writes outside that window have no effect on it.
- R3: With main-select 0, the boot ROM is selected, and PRG address bits 14..0 equal CPU A14..A0 with all higher bits 0.
- R4: With main-select 1 and core-mode 1, the PRG address is {outer bank, low 4 bits of the core's 8 KB bank, A12..A0}.
- R5: With main-select 1, core-mode 0 and outer bank 0, the PRG address is {outer bank, inner page, A13..A0}, so the same 16 KB page appears at 0x8000 and 0xC000.
- R6: With main-select 1, core-mode 0 and a non-zero outer bank, the PRG address is {outer bank, inner page bits 2..1, A14, A13..A0}.
- R7: After the lock bit is written as 1, later register writes change nothing until reset.
- R8: Once main-select is 1, a later write cannot clear it, while the other fields still load.
- R9: The protect snoop captures data bit 7 (enable) and bit 6 (protect) on CPU writes to even addresses in 0xA000-0xBFFF. The register loads only while enable is 1 and protect is 0. Writes to odd addresses leave the snoop unchanged.
- R10: CHR upper address is {outer bank, low 7 bits of the core's 1 KB CHR bank} in every mode, including boot-ROM mode.
- R11: The main-ROM select is active only for CPU reads at A15 = 1 with main-select 1. The boot-ROM select is active only for such reads with main-select 0. The two selects are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst | input | 1 | Synchronous active-high reset (power-up, soft or hard) |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus, used only by the protect snoop |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| cpu_rd | input | 1 | CPU read qualifier |
| core_prg_bank | input | 4 | Low bits of the core's 8 KB PRG bank for the active slot |
| core_chr_bank | input | 7 | Low bits of the core's 1 KB CHR bank |
| prg_addr | output | 19 | PRG ROM address (boot ROM uses bits 14..0) |
| main_rom_sel | output | 1 | Chip select for the 512 KB main ROM |
| boot_rom_sel | output | 1 | Chip select for the 32 KB boot ROM |
| chr_addr_hi | output | 9 | CHR address bits 18..10 |

## Verification
The outer register is not visible at the ports, so a wrong internal state shows up only in the next read's ROM select and PRG address. It can also show in the CHR upper lines, which reflect the outer bank one cycle after the accepted write.

The directed tests therefore probe reads at both halves of the PRG window after every write. Some of those writes should load the register and some should be refused. Refused writes cover the protect snoop, the lock bit, the address window and the sticky select. A bad field decode or a lost lock shows up as a wrong address within one cycle.

// File: rtl/mb_pkg.sv
package mb_pkg;

    // Field geometry of the outer register.
    localparam int OUTER_W = 2;   // outer 128 KB bank select
    localparam int INNER_W = 3;   // fixed-mode 16 KB page
    localparam int CORE_W  = 4;   // core 8 KB bank bits kept
    localparam int CHRB_W  = 7;   // core 1 KB CHR bank bits kept

    // Address bit positions the register decodes (software contract).
    localparam int POS_MAIN  = 8;
    localparam int POS_LOCK  = 6;
    localparam int POS_CORE  = 5;
    localparam int POS_OUTER = 3;
    localparam int POS_INNER = 0;

    localparam int PAGE16_AW = 14;
    localparam int PAGE8_AW  = 13;
    localparam int PRG_AW    = OUTER_W + INNER_W + PAGE16_AW;
    localparam int CHR_HI_W  = OUTER_W + CHRB_W;

    typedef struct packed {
        logic               main_sel;
        logic               lock;
        logic               core_mode;
        logic [OUTER_W-1:0] outer;
        logic [INNER_W-1:0] inner;
    } outer_reg_t;

    typedef enum logic [1:0] {
        MAP_BOOT  = 2'd0,
        MAP_CORE  = 2'd1,
        MAP_FIX16 = 2'd2,
        MAP_FIX32 = 2'd3
    } map_mode_e;

    function automatic map_mode_e pick_mode(input outer_reg_t r);
        if (!r.main_sel)          return MAP_BOOT;
        else if (r.core_mode)     return MAP_CORE;
        else if (r.outer == '0)   return MAP_FIX16;
        else                      return MAP_FIX32;
    endfunction

    // Next register value for an accepted write; main_sel is sticky.
    function automatic outer_reg_t load_from_addr(input outer_reg_t cur,
                                                  input logic [15:0] a);
        outer_reg_t n;
        n.main_sel  = cur.main_sel | a[POS_MAIN];
        n.lock      = a[POS_LOCK];
        n.core_mode = a[POS_CORE];
        n.outer     = a[POS_OUTER +: OUTER_W];
        n.inner     = a[POS_INNER +: INNER_W];
        return n;
    endfunction

endpackage

// File: rtl/mb_prot_snoop.sv
module mb_prot_snoop
    import mb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_wr,
    output logic        wr_ok
);
    logic en_q, prot_q;
    logic snoop_hit;
    logic unused_bits;

    assign snoop_hit   = cpu_wr && (cpu_addr[15:13] == 3'b101) && !cpu_addr[0];
    assign unused_bits = ^{cpu_addr[12:1], cpu_data[5:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            prot_q <= 1'b0;
        end else if (snoop_hit) begin
            en_q   <= cpu_data[7];
            prot_q <= cpu_data[6];
        end
    end

    assign wr_ok = en_q && !prot_q;

    AST_SNOOP_ODD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'b101 && cpu_addr[0]) |=> $stable({en_q, prot_q})); // R9
    AST_SNOOP_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cpu_wr |=> $stable(wr_ok)); // R9

endmodule

// File: rtl/mb_outer_reg.sv
module mb_outer_reg
    import mb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_wr,
    input  logic        wr_ok,
    output outer_reg_t  reg_q
);
    logic win_hit, accept;
    logic unused_bits;

    assign win_hit     = cpu_wr && (cpu_addr[15:13] == 3'b011);
    assign accept      = win_hit && wr_ok && !reg_q.lock;
    assign unused_bits = ^{cpu_addr[12:9], cpu_addr[7]};

    always_ff @(posedge clk) begin
        if (rst)
            reg_q <= '0;
        else if (accept)
            reg_q <= load_from_addr(reg_q, cpu_addr);
    end

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        reg_q.lock |=> $stable(reg_q)); // R7
    AST_MAIN_STICKY: assert property (@(posedge clk) disable iff (rst)
        reg_q.main_sel |=> reg_q.main_sel); // R8
    AST_PROTECT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> $stable(reg_q)); // R9
    AST_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] != 3'b011) |=> $stable(reg_q)); // R2
    AST_OUTER_LOADS: assert property (@(posedge clk) disable iff (rst)
        (win_hit && wr_ok && !reg_q.lock) |=> reg_q.outer == $past(cpu_addr[4:3])); // R2

endmodule

// File: rtl/mb_prg_map.sv
module mb_prg_map
    import mb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  outer_reg_t        reg_q,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rd,
    input  logic [CORE_W-1:0] core_prg_bank,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              main_rom_sel,
    output logic              boot_rom_sel
);
    map_mode_e mode;
    logic      rom_rd;

    assign mode   = pick_mode(reg_q);
    assign rom_rd = cpu_rd && cpu_addr[15];

    always_comb begin
        prg_addr = '0;
        unique case (mode)
            MAP_BOOT:  prg_addr[14:0] = cpu_addr[14:0];
            MAP_CORE:  prg_addr = {reg_q.outer, core_prg_bank,
                                   cpu_addr[PAGE8_AW-1:0]};
            MAP_FIX16: prg_addr = {reg_q.outer, reg_q.inner,
                                   cpu_addr[PAGE16_AW-1:0]};
            MAP_FIX32: prg_addr = {reg_q.outer, reg_q.inner[INNER_W-1:1],
                                   cpu_addr[14], cpu_addr[PAGE16_AW-1:0]};
            default:   prg_addr = '0;
        endcase
    end

    assign main_rom_sel = rom_rd &&  reg_q.main_sel;
    assign boot_rom_sel = rom_rd && !reg_q.main_sel;

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({main_rom_sel, boot_rom_sel})); // R11
    AST_SEL_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (main_rom_sel || boot_rom_sel) |-> (cpu_rd && cpu_addr[15])); // R11
    AST_BOOT_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        boot_rom_sel |-> (prg_addr[PRG_AW-1:15] == '0)); // R3
    AST_FIX16_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (mode == MAP_FIX16) |-> (prg_addr[PAGE16_AW-1:0] == cpu_addr[PAGE16_AW-1:0])); // R5

endmodule

// File: rtl/mb_multicart_mapper.sv
module mb_multicart_mapper
    import mb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [15:0]         cpu_addr,
    input  logic [7:0]          cpu_data,
    input  logic                cpu_wr,
    input  logic                cpu_rd,
    input  logic [CORE_W-1:0]   core_prg_bank,
    input  logic [CHRB_W-1:0]   core_chr_bank,
    output logic [PRG_AW-1:0]   prg_addr,
    output logic                main_rom_sel,
    output logic                boot_rom_sel,
    output logic [CHR_HI_W-1:0] chr_addr_hi
);
    logic       wr_ok;
    outer_reg_t reg_q;

    mb_prot_snoop u_snoop (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .wr_ok    (wr_ok)
    );

    mb_outer_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .wr_ok    (wr_ok),
        .reg_q    (reg_q)
    );

    mb_prg_map u_map (
        .clk           (clk),
        .rst           (rst),
        .reg_q         (reg_q),
        .cpu_addr      (cpu_addr),
        .cpu_rd        (cpu_rd),
        .core_prg_bank (core_prg_bank),
        .prg_addr      (prg_addr),
        .main_rom_sel  (main_rom_sel),
        .boot_rom_sel  (boot_rom_sel)
    );

    // Outer bank confines CHR in every mode.
    assign chr_addr_hi = {reg_q.outer, core_chr_bank};

    AST_CHR_OUTER_STABLE: assert property (@(posedge clk) disable iff (rst)
        !cpu_wr |=> $stable(chr_addr_hi[CHR_HI_W-1:CHRB_W])); // R10

endmodule

// File: tb/tb_mb_multicart_mapper.sv
module tb_mb_multicart_mapper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [3:0]  core_prg_bank = 4'hB;
    logic [6:0]  core_chr_bank = 7'h45;
    logic [18:0] prg_addr;
    logic        main_rom_sel, boot_rom_sel;
    logic [8:0]  chr_addr_hi;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mb_multicart_mapper dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .core_prg_bank(core_prg_bank),
        .core_chr_bank(core_chr_bank), .prg_addr(prg_addr),
        .main_rom_sel(main_rom_sel), .boot_rom_sel(boot_rom_sel),
        .chr_addr_hi(chr_addr_hi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // Read probe: checks selects and PRG address.
    task automatic probe(input string req, input logic [15:0] a, input logic main_e,
                         input logic boot_e, input logic [18:0] pa_e);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
        chk({req, " main_sel"}, main_rom_sel, main_e);
        chk({req, " boot_sel"}, boot_rom_sel, boot_e);
        chk({req, " prg_addr"}, prg_addr, pa_e);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; cpu_wr = 1'b0; cpu_rd = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        probe("R1/R3", 16'h8123, 1'b0, 1'b1, 19'h00123);
        probe("R3", 16'hFFFF, 1'b0, 1'b1, 19'h07FFF);
        chk("R10 boot", chr_addr_hi, 9'h045);
    endtask

    task automatic t_snoop_gate();
        cpu_write(16'h6100, 8'h00);                 // snoop still disabled
        probe("R9 disabled", 16'h8000, 1'b0, 1'b1, 19'h00000);
        cpu_write(16'hA001, 8'h80);                 // odd address: ignored
        cpu_write(16'h6100, 8'h00);
        probe("R9 odd", 16'h8000, 1'b0, 1'b1, 19'h00000);
        cpu_write(16'hA000, 8'h80);                 // enable
        cpu_write(16'h4109, 8'h00);                 // outside window
        probe("R2 window", 16'h8000, 1'b0, 1'b1, 19'h00000);
    endtask

    task automatic t_fixed32();
        cpu_write(16'h610D, 8'hFF);                 // main=1 outer=1 inner=5
        probe("R6 low", 16'h9234, 1'b1, 1'b0, 19'h31234);
        probe("R6 high", 16'hC234, 1'b1, 1'b0, 19'h34234);
        chk("R10 fix32", chr_addr_hi, 9'h0C5);
    endtask

    task automatic t_sticky_fixed16();
        cpu_write(16'h6003, 8'h00);                 // main bit 0 written
        probe("R8/R5 low", 16'h8010, 1'b1, 1'b0, 19'h0C010);
        probe("R5 high", 16'hC010, 1'b1, 1'b0, 19'h0C010);
        chk("R10 fix16", chr_addr_hi, 9'h045);
    endtask

    task automatic t_core_mode();
        cpu_write(16'h6138, 8'h00);                 // outer=3 core-mode
        core_prg_bank = 4'hB;
        probe("R4", 16'hA055, 1'b1, 1'b0, 19'h76055);
        chk("R10 core", chr_addr_hi, 9'h1C5);
        core_prg_bank = 4'h2;
        probe("R4 bank2", 16'hE001, 1'b1, 1'b0, 19'h64001);
    endtask

    task automatic t_protect();
        cpu_write(16'hA000, 8'hC0);                 // protect on
        cpu_write(16'h6100, 8'h00);
        probe("R9 protect", 16'hE001, 1'b1, 1'b0, 19'h64001);
        cpu_write(16'hA000, 8'h00);                 // disable
        cpu_write(16'h6100, 8'h00);
        probe("R9 off", 16'hE001, 1'b1, 1'b0, 19'h64001);
        cpu_write(16'hA000, 8'h80);
    endtask

    task automatic t_lock();
        cpu_write(16'h6149, 8'h00);                 // lock, outer=1 inner=1
        probe("R7 loaded", 16'h8000, 1'b1, 1'b0, 19'h20000);
        probe("R6 p21=0", 16'hC000, 1'b1, 1'b0, 19'h24000);
        cpu_write(16'h6138, 8'h00);
        probe("R7 frozen", 16'h8000, 1'b1, 1'b0, 19'h20000);
        chk("R7 chr", chr_addr_hi, 9'h0C5);
    endtask

    task automatic t_selects();
        @(negedge clk); cpu_addr = 16'h8000; cpu_rd = 1'b0; cpu_wr = 1'b0; #1;
        chk("R11 no read", {30'd0, main_rom_sel, boot_rom_sel}, 32'd0);
        @(negedge clk); cpu_addr = 16'h7000; cpu_rd = 1'b1; #1;
        chk("R11 low addr", {30'd0, main_rom_sel, boot_rom_sel}, 32'd0);
        cpu_rd = 1'b0;
        cpu_write(16'h8000, 8'h00);
        chk("R11 write", {30'd0, main_rom_sel, boot_rom_sel}, 32'd0);
    endtask

    task automatic t_reset_again();
        do_reset();
        probe("R1 rereset", 16'h8000, 1'b0, 1'b1, 19'h00000);
        chk("R1 chr", chr_addr_hi, 9'h045);
        cpu_write(16'hA000, 8'h80);
        cpu_write(16'h610D, 8'h00);
        probe("R1 unlock", 16'h9234, 1'b1, 1'b0, 19'h31234);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset_state();
        t_snoop_gate();
        t_fixed32();
        t_sticky_fixed16();
        t_core_mode();
        t_protect();
        t_lock();
        t_selects();
        t_reset_again();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule